// File: doc/BRIEF.md
# Strided Scatter Address Generator

This block takes one packet of a contiguous message and turns it into a burst of DMA write commands. Each command places one fixed-size block of the packet payload into host memory. The blocks land at addresses spaced by a configured stride, so the message is laid out as a vector datatype: equal blocks with gaps between them. Each command carries a source address in the payload buffer, a destination address in host memory and a byte length. No command requests a completion event, and none waits on an earlier one.

Each packet arrives with three fields: its payload buffer address, its payload length and its byte offset within the whole message. The block finds the packet's first destination from that offset alone, so packets can be handled in any order and no state carries over from one packet to the next. The block size is a power of two, given as a log2 field. The stride is given in bytes. The host base address is the start of the message in host memory.

Top module: `scatter_agen`

## Requirements
- R1: After reset, `pkt_ready` is 1, and `cmd_valid`, `done` and `err` are 0.
- R2: An accepted packet with a valid descriptor produces exactly `pkt_len >> cfg_blk_log2` commands.
- R3: The first command of a packet has source `pkt_src` and destination `host_base + (pkt_ofs >> cfg_blk_log2) * cfg_stride`, computed modulo 2^ADDR_W.
- R4: Every command has `cmd_len = 2^cfg_blk_log2`. Each later command of the same packet has a source larger by that block size and a destination larger by `cfg_stride`.
- R5: `pkt_ready` is 0 whenever a command is pending, so no new descriptor can be taken mid-packet.
- R6: While `cmd_valid` is 1 and `cmd_ready` is 0, the command fields stay unchanged into the next cycle.
- R7: A packet with `pkt_len = 0` and an aligned offset emits no command. `done` is 1 for exactly the one cycle after acceptance, and `pkt_ready` stays 1.
- R8: A packet whose length or offset is not a multiple of the block size emits no command. `err` is 1 for the one cycle after acceptance, and `done` stays 0.
- R9: In the cycle after the last command's handshake, `done` is 1 for one cycle, `cmd_valid` is 0 and `pkt_ready` is 1 again.
- R10: The commands for a packet depend only on its own descriptor, whatever packets came before it and in whatever order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet descriptor offered |
| pkt_ready | output | 1 | Block idle; descriptor taken when pkt_valid is also 1 |
| pkt_src | input | ADDR_W | Payload buffer address of the packet |
| pkt_len | input | LEN_W | Payload length in bytes |
| pkt_ofs | input | OFS_W | Byte offset of the packet within the message |
| cfg_blk_log2 | input | LOG2_W | log2 of block size in bytes |
| cfg_stride | input | ADDR_W | Destination stride in bytes |
| host_base | input | ADDR_W | Host address of the message start |
| cmd_valid | output | 1 | DMA command offered |
| cmd_ready | input | 1 | DMA engine takes the command |
| cmd_src | output | ADDR_W | Command source address |
| cmd_dst | output | ADDR_W | Command destination address |
| cmd_len | output | LEN_W | Command length in bytes |
| done | output | 1 | One-cycle pulse when a packet finishes |
| err | output | 1 | One-cycle pulse when a misaligned packet is dropped |

## Verification
The assertions make three assumptions about the inputs:
- The descriptor and configuration inputs matter only in the cycle a packet is accepted.
- `cfg_blk_log2` stays below LEN_W, so the block size fits in `cmd_len`.
- `cmd_ready` may change freely from cycle to cycle.

The bench keeps to these assumptions:
- It changes the descriptor only while `pkt_ready` is high, one packet at a time.
- It sweeps `cfg_blk_log2` only over 0 to 3, with stride always larger than the block size.
- It drives `cmd_ready` from a pseudo-random sequence or holds it high, so both stalls and back-to-back handshakes occur.

// File: rtl/scatter_pkg.sv
package scatter_pkg;
  localparam int MAXW = 64;
  typedef logic [MAXW-1:0] wide_t;

  typedef enum logic {W_IDLE = 1'b0, W_RUN = 1'b1} walk_state_e;

  // block size in bytes from its log2 field
  function automatic wide_t pow2(input logic [5:0] lg);
    return wide_t'(1) << lg;
  endfunction

  // true when v is a whole number of blocks
  function automatic logic is_multiple(input wide_t v, input logic [5:0] lg);
    return (v & (pow2(lg) - wide_t'(1))) == '0;
  endfunction

  // number of whole blocks in v bytes (division by shift)
  function automatic wide_t units(input wide_t v, input logic [5:0] lg);
    return v >> lg;
  endfunction

  // destination of the first block of a packet at byte offset ofs
  function automatic wide_t first_dst(input wide_t base, input wide_t ofs,
                                      input logic [5:0] lg, input wide_t stride);
    return base + units(ofs, lg) * stride;
  endfunction
endpackage

// File: rtl/scatter_setup.sv
module scatter_setup #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int OFS_W  = 32,
  parameter int LOG2_W = 4
) (
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [OFS_W-1:0]  pkt_ofs,
  input  logic [LOG2_W-1:0] cfg_blk_log2,
  input  logic [ADDR_W-1:0] cfg_stride,
  input  logic [ADDR_W-1:0] host_base,
  output logic              aligned,
  output logic              empty,
  output logic [LEN_W-1:0]  blk_count,
  output logic [LEN_W-1:0]  blk_bytes,
  output logic [ADDR_W-1:0] start_dst
);
  import scatter_pkg::*;

  logic [5:0] lg;
  wide_t      w_len;
  wide_t      w_ofs;

  always_comb begin
    lg        = 6'(cfg_blk_log2);
    w_len     = wide_t'(pkt_len);
    w_ofs     = wide_t'(pkt_ofs);
    aligned   = is_multiple(w_len, lg) && is_multiple(w_ofs, lg);
    empty     = (pkt_len == '0);
    blk_count = LEN_W'(units(w_len, lg));
    blk_bytes = LEN_W'(pow2(lg));
    start_dst = ADDR_W'(first_dst(wide_t'(host_base), w_ofs, lg, wide_t'(cfg_stride)));
  end
endmodule

// File: rtl/scatter_walker.sv
module scatter_walker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              zero_ok,
  input  logic              bad,
  input  logic [ADDR_W-1:0] ld_src,
  input  logic [ADDR_W-1:0] ld_dst,
  input  logic [LEN_W-1:0]  ld_cnt,
  input  logic [LEN_W-1:0]  ld_bs,
  input  logic [ADDR_W-1:0] ld_stride,
  input  logic              cmd_ready,
  output logic              busy,
  output logic [ADDR_W-1:0] cmd_src,
  output logic [ADDR_W-1:0] cmd_dst,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              step,
  output logic              last,
  output logic [ADDR_W-1:0] stride_o,
  output logic              done,
  output logic              err
);
  import scatter_pkg::*;

  walk_state_e       state_q;
  logic [ADDR_W-1:0] src_q, dst_q, stride_q;
  logic [LEN_W-1:0]  rem_q, bs_q;
  logic              done_q, err_q;

  assign busy     = (state_q == W_RUN);
  assign step     = busy && cmd_ready;
  assign last     = (rem_q == LEN_W'(1));
  assign cmd_src  = src_q;
  assign cmd_dst  = dst_q;
  assign cmd_len  = bs_q;
  assign stride_o = stride_q;
  assign done     = done_q;
  assign err      = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= W_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      stride_q <= '0;
      rem_q    <= '0;
      bs_q     <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= zero_ok || (step && last);
      err_q  <= bad;
      unique case (state_q)
        W_IDLE: begin
          if (load) begin
            state_q  <= W_RUN;
            src_q    <= ld_src;
            dst_q    <= ld_dst;
            stride_q <= ld_stride;
            rem_q    <= ld_cnt;
            bs_q     <= ld_bs;
          end
        end
        W_RUN: begin
          if (step) begin
            src_q <= src_q + ADDR_W'(bs_q);
            dst_q <= dst_q + stride_q;
            rem_q <= rem_q - LEN_W'(1);
            if (last) state_q <= W_IDLE;
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scatter_agen.sv
module scatter_agen #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int OFS_W  = 32,
  parameter int LOG2_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic [ADDR_W-1:0] pkt_src,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [OFS_W-1:0]  pkt_ofs,
  input  logic [LOG2_W-1:0] cfg_blk_log2,
  input  logic [ADDR_W-1:0] cfg_stride,
  input  logic [ADDR_W-1:0] host_base,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_src,
  output logic [ADDR_W-1:0] cmd_dst,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              done,
  output logic              err
);
  logic              accept, aligned, empty;
  logic              load, zero_ok, bad;
  logic              busy, walk_step, walk_last;
  logic [LEN_W-1:0]  blk_count, blk_bytes;
  logic [ADDR_W-1:0] start_dst, walk_stride;

  assign pkt_ready = !busy;
  assign cmd_valid = busy;
  assign accept    = pkt_valid && pkt_ready;
  assign load      = accept && aligned && !empty;
  assign zero_ok   = accept && aligned && empty;
  assign bad       = accept && !aligned;

  scatter_setup #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFS_W(OFS_W), .LOG2_W(LOG2_W)) u_setup (
    .pkt_len      (pkt_len),
    .pkt_ofs      (pkt_ofs),
    .cfg_blk_log2 (cfg_blk_log2),
    .cfg_stride   (cfg_stride),
    .host_base    (host_base),
    .aligned      (aligned),
    .empty        (empty),
    .blk_count    (blk_count),
    .blk_bytes    (blk_bytes),
    .start_dst    (start_dst)
  );

  scatter_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .zero_ok   (zero_ok),
    .bad       (bad),
    .ld_src    (pkt_src),
    .ld_dst    (start_dst),
    .ld_cnt    (blk_count),
    .ld_bs     (blk_bytes),
    .ld_stride (cfg_stride),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .cmd_src   (cmd_src),
    .cmd_dst   (cmd_dst),
    .cmd_len   (cmd_len),
    .step      (walk_step),
    .last      (walk_last),
    .stride_o  (walk_stride),
    .done      (done),
    .err       (err)
  );
endmodule

// File: rtl/scatter_agen_chk.sv
module scatter_agen_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_src,
  input logic [ADDR_W-1:0] cmd_dst,
  input logic [LEN_W-1:0]  cmd_len,
  input logic              done,
  input logic              err,
  input logic              walk_last,
  input logic [ADDR_W-1:0] walk_stride
);
  AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_src) && $stable(cmd_dst) && $stable(cmd_len))); // R6

  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !walk_last) |=> (cmd_src == $past(cmd_src) + ADDR_W'($past(cmd_len)))); // R4

  AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !walk_last) |=> (cmd_dst == $past(cmd_dst) + $past(walk_stride))); // R4

  AST_LEN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !walk_last) |=> $stable(cmd_len)); // R4

  AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && walk_last) |=> (done && pkt_ready && !cmd_valid)); // R9

  AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R8

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (pkt_ready && !cmd_valid)); // R8
endmodule

bind scatter_agen scatter_agen_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pkt_ready   (pkt_ready),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_src     (cmd_src),
  .cmd_dst     (cmd_dst),
  .cmd_len     (cmd_len),
  .done        (done),
  .err         (err),
  .walk_last   (walk_last),
  .walk_stride (walk_stride)
);

// File: tb/tb_scatter_agen.sv
module tb_scatter_agen;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int OFS_W  = 32;
  localparam int LOG2_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pkt_valid = 1'b0;
  logic              pkt_ready;
  logic [ADDR_W-1:0] pkt_src = '0;
  logic [LEN_W-1:0]  pkt_len = '0;
  logic [OFS_W-1:0]  pkt_ofs = '0;
  logic [LOG2_W-1:0] cfg_blk_log2 = '0;
  logic [ADDR_W-1:0] cfg_stride = '0;
  logic [ADDR_W-1:0] host_base = '0;
  logic              cmd_valid;
  logic              cmd_ready = 1'b0;
  logic [ADDR_W-1:0] cmd_src, cmd_dst;
  logic [LEN_W-1:0]  cmd_len;
  logic              done, err;

  int   n_total = 0;
  int   n_fail  = 0;
  bit   finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  scatter_agen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFS_W(OFS_W), .LOG2_W(LOG2_W)) dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_src(pkt_src), .pkt_len(pkt_len), .pkt_ofs(pkt_ofs), .cfg_blk_log2(cfg_blk_log2),
    .cfg_stride(cfg_stride), .host_base(host_base), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_pkt(input logic [31:0] src, input int len, input int ofs, input int lg,
                         input logic [31:0] stride, input logic [31:0] base, input bit bp);
    int bs = 1 << lg;
    bit good = ((len % bs) == 0) && ((ofs % bs) == 0);
    int n_exp = good ? len / bs : 0;
    int k = 0;
    int cyc = 0;
    bit held = 1'b0;
    bit seen_done = 1'b0;
    bit seen_err = 1'b0;
    bit r;
    logic [31:0] hs = '0, hd = '0, es, ed;
    chk(pkt_ready == 1'b1, "R5", "idle before packet", longint'(pkt_ready), 1);
    pkt_src = src; pkt_len = LEN_W'(len); pkt_ofs = OFS_W'(ofs);
    cfg_blk_log2 = LOG2_W'(lg); cfg_stride = stride; host_base = base;
    pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
    pkt_len = 16'h7FFF; pkt_ofs = 32'h1234_5671; cfg_stride = 32'hDEAD_0001;
    while (cyc < 400) begin
      if (done) seen_done = 1'b1;
      if (err) seen_err = 1'b1;
      if (done || err) break;
      if (cmd_valid) begin
        chk(!pkt_ready, "R5", "pkt_ready while command pending", longint'(pkt_ready), 0);
        if (held) begin
          chk(cmd_src == hs, "R6", "src held under stall", longint'(cmd_src), longint'(hs));
          chk(cmd_dst == hd, "R6", "dst held under stall", longint'(cmd_dst), longint'(hd));
        end
        chk(k < n_exp, "R2", "unexpected extra command", k, n_exp);
        es = src + 32'(k * bs);
        ed = base + 32'(ofs / bs) * stride + 32'(k) * stride;
        if (k == 0) begin
          chk(cmd_src == es, "R3", "first src", longint'(cmd_src), longint'(es));
          chk(cmd_dst == ed, "R3", "first dst", longint'(cmd_dst), longint'(ed));
        end else begin
          chk(cmd_src == es, "R4", "src step", longint'(cmd_src), longint'(es));
          chk(cmd_dst == ed, "R4", "dst step", longint'(cmd_dst), longint'(ed));
        end
        chk(cmd_len == LEN_W'(bs), "R4", "cmd_len", longint'(cmd_len), bs);
        r = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
        cmd_ready = r;
        held = !r;
        hs = cmd_src; hd = cmd_dst;
        if (r) k++;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
      cyc++;
    end
    cmd_ready = 1'b0;
    if (cyc >= 400) chk(1'b0, "R9", "packet watchdog", cyc, 0);
    chk(k == n_exp, "R2", "command count", k, n_exp);
    if (!good) begin
      chk(seen_err, "R8", "err pulse on misaligned", longint'(seen_err), 1);
      chk(!seen_done, "R8", "no done on misaligned", longint'(seen_done), 0);
    end else if (len == 0) begin
      chk(seen_done && cyc == 0, "R7", "immediate done on zero length", cyc, 0);
      chk(pkt_ready, "R7", "ready with zero-length done", longint'(pkt_ready), 1);
    end else begin
      chk(seen_done && !seen_err, "R9", "done after last command", longint'(seen_done), 1);
      chk(!cmd_valid && pkt_ready, "R9", "released with done", longint'(cmd_valid), 0);
    end
    @(negedge clk);
    chk(!done && !err, "R9", "status is a single pulse", longint'({done, err}), 0);
    chk(pkt_ready, "R9", "idle after packet", longint'(pkt_ready), 1);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_total++; n_fail++;
      $display("FAIL R1 global watchdog expired: actual=0 expected=1");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pkt_ready == 1'b1, "R1", "reset pkt_ready", longint'(pkt_ready), 1);
    chk(cmd_valid == 1'b0, "R1", "reset cmd_valid", longint'(cmd_valid), 0);
    chk(!done && !err, "R1", "reset done/err", longint'({done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // sweep: block size, stride, block count, offset order (R2 R3 R4 R6 R7 R9 R10)
    for (int lg = 0; lg < 4; lg++) begin
      for (int sm = 2; sm < 4; sm++) begin
        for (int nb = 0; nb < 5; nb++) begin
          for (int oi = 0; oi < 4; oi++) begin
            int ob = (oi == 0) ? 3 : (oi == 1) ? 1 : (oi == 2) ? 0 : 2;
            int bs = 1 << lg;
            run_pkt(32'h1000 + 32'(nb * 64), nb * bs, ob * bs, lg,
                    32'(bs * sm + sm), 32'h8000_0000 + 32'(lg * 256), ((nb + ob) % 2) == 1);
          end
        end
      end
    end
    // misaligned length or offset (R8)
    for (int lg = 1; lg < 4; lg++) begin
      int bs = 1 << lg;
      run_pkt(32'h2000, 2 * bs + 1, 0, lg, 32'(4 * bs), 32'h4000, 1'b0);
      run_pkt(32'h2000, bs, bs + 1, lg, 32'(4 * bs), 32'h4000, 1'b0);
      run_pkt(32'h2000, 0, 1, lg, 32'(4 * bs), 32'h4000, 1'b0);
    end
    // same descriptor repeated after unrelated traffic gives same commands (R10)
    run_pkt(32'h3000, 16, 40, 2, 32'd20, 32'hFFFF_FF00, 1'b1);
    run_pkt(32'h5000, 8, 0, 3, 32'd24, 32'h0, 1'b0);
    run_pkt(32'h3000, 16, 40, 2, 32'd20, 32'hFFFF_FF00, 1'b1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule